// File: doc/BRIEF.md
# Pipeline Trap Priority Resolver

This block picks the single trap a small in-order core takes when faults appear in more than one pipeline stage in the same cycle. It watches the fault flags and PC of the instruction in decode/execute and, when the core is built with a writeback stage, the memory fault reported by the instruction completing in writeback. Each cycle it decides whether a synchronous trap is taken, which cause code and trap value go with it, whether the decode-stage instruction may move on, and whether that instruction must wait for an older one still in writeback.

A build-time parameter picks the two-stage or three-stage arrangement. With a writeback stage, memory faults come from writeback and outrank anything in decode/execute. Without it, memory faults belong to the execute-stage instruction and rank below its decode faults. A load whose return data fails its integrity check raises no synchronous trap. It sets a pending non-maskable interrupt request instead, which stays up until the core reports that the handler has been entered. The trap strobe, cause, value and flush request are registered and appear one cycle after the deciding inputs.

Top module: `exc_arbiter`

## Requirements
- R1: After reset, trap_o, cause_o, tval_o, flush_o and nmi_req_o are all zero.
- R2: Among decode/execute faults of a valid instruction the order is fetch error (cause 1), then illegal instruction (cause 2), then ecall (cause 11), then ebreak (cause 3).
- R3: The trap value is the PC for a fetch error, or the PC plus 2 when idx_fetch_hi_i marks a fault in the second half. It is the PC for ebreak, 0 for illegal instruction and ecall, and the memory address for a load/store fault.
- R4: With the writeback stage (WB_STAGE=1), a writeback load fault (cause 5) or store fault (cause 7, wb_store_i=1) wins over any decode/execute fault in the same cycle.
- R5: With WB_STAGE=1, a decode/execute fault seen while writeback holds an instruction that has not completed (wb_valid_i=1, wb_done_i=0) is not taken and raises id_hold_o. It is resolved in the cycle writeback completes without a fault.
- R6: With WB_STAGE=1, a writeback fault is taken even when idx_valid_i is 0.
- R7: With WB_STAGE=0, the decode/execute memory fault (cause 5 load, 7 store) ranks below all of R2, and all writeback inputs have no effect.
- R8: An integrity error on load data sets nmi_req_o from the next cycle and raises no trap_o. The request stays set until nmi_ack_i, and a new error in the cycle of an acknowledge keeps it set.
- R9: trap_o, cause_o and tval_o follow the deciding cycle by one clock. flush_o is set on that cycle for every taken trap and also one cycle after nmi_ack_i.
- R10: id_adv_o is 1 only for a valid decode instruction with no fault of its own and no writeback fault being taken. It is 0 whenever that instruction traps or is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_valid_i | input | 1 | Valid instruction in decode/execute |
| idx_pc_i | input | XLEN | PC of that instruction |
| idx_fetch_err_i | input | 1 | Fetch error |
| idx_fetch_hi_i | input | 1 | Fetch error lies in the second half of an unaligned instruction |
| idx_illegal_i | input | 1 | Illegal instruction |
| idx_ecall_i | input | 1 | Environment call |
| idx_ebreak_i | input | 1 | Breakpoint instruction |
| idx_mem_err_i | input | 1 | Memory fault of the execute instruction (two-stage only) |
| idx_mem_store_i | input | 1 | That fault is from a store |
| idx_mem_addr_i | input | XLEN | Faulting memory address (two-stage) |
| wb_valid_i | input | 1 | Instruction present in writeback |
| wb_done_i | input | 1 | Writeback instruction completes this cycle |
| wb_err_i | input | 1 | Memory fault reported on completion |
| wb_store_i | input | 1 | Writeback fault is from a store |
| wb_addr_i | input | XLEN | Writeback faulting address |
| intg_err_i | input | 1 | Integrity error in load return data |
| nmi_ack_i | input | 1 | Non-maskable interrupt handler entered |
| trap_o | output | 1 | Synchronous trap taken |
| cause_o | output | 5 | Trap cause code |
| tval_o | output | XLEN | Trap value |
| flush_o | output | 1 | Pipeline flush request |
| nmi_req_o | output | 1 | Pending non-maskable interrupt |
| id_adv_o | output | 1 | Decode instruction may advance |
| id_hold_o | output | 1 | Decode fault waits for writeback |

## Verification
Two collisions matter most. The first is a writeback memory fault completing in the same cycle as a decode/execute fault. The second is an integrity error or handler acknowledge arriving together with a synchronous trap. Both build variants sit side by side on the same stimulus, so each collision is judged under both priority schemes. A behavioural model recomputes the winner, hold and advance every cycle and compares them with the registered outputs one clock later. It also follows the pending interrupt, including a new error that lands in the acknowledge cycle.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
    typedef enum logic [4:0] {
        CAUSE_NONE    = 5'd0,
        CAUSE_FETCH   = 5'd1,
        CAUSE_ILLEGAL = 5'd2,
        CAUSE_BREAK   = 5'd3,
        CAUSE_LOAD    = 5'd5,
        CAUSE_STORE   = 5'd7,
        CAUSE_ECALL   = 5'd11
    } cause_e;
endpackage

// File: rtl/id_fault_sel.sv
module id_fault_sel
    import exc_arb_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit INCL_MEM = 1'b0
) (
    input  logic            valid_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            fetch_err_i,
    input  logic            fetch_hi_i,
    input  logic            illegal_i,
    input  logic            ecall_i,
    input  logic            ebreak_i,
    input  logic            mem_err_i,
    input  logic            mem_store_i,
    input  logic [XLEN-1:0] mem_addr_i,
    output logic            fault_o,
    output cause_e          cause_o,
    output logic [XLEN-1:0] tval_o
);
    localparam logic [XLEN-1:0] HALF_STEP = XLEN'(2);

    logic            mem_fault;
    cause_e          mem_cause;
    logic [XLEN-1:0] mem_tval;

    generate
        if (INCL_MEM) begin : g_mem
            assign mem_fault = mem_err_i;
            assign mem_cause = mem_store_i ? CAUSE_STORE : CAUSE_LOAD;
            assign mem_tval  = mem_addr_i;
        end else begin : g_nomem
            logic unused_mem_in;
            assign unused_mem_in = ^{mem_err_i, mem_store_i, mem_addr_i};
            assign mem_fault = 1'b0;
            assign mem_cause = CAUSE_NONE;
            assign mem_tval  = '0;
        end
    endgenerate

    always_comb begin
        fault_o = 1'b0;
        cause_o = CAUSE_NONE;
        tval_o  = '0;
        if (valid_i) begin
            if (fetch_err_i) begin
                fault_o = 1'b1;
                cause_o = CAUSE_FETCH;
                tval_o  = fetch_hi_i ? pc_i + HALF_STEP : pc_i;
            end else if (illegal_i) begin
                fault_o = 1'b1;
                cause_o = CAUSE_ILLEGAL;
            end else if (ecall_i) begin
                fault_o = 1'b1;
                cause_o = CAUSE_ECALL;
            end else if (ebreak_i) begin
                fault_o = 1'b1;
                cause_o = CAUSE_BREAK;
                tval_o  = pc_i;
            end else if (mem_fault) begin
                fault_o = 1'b1;
                cause_o = mem_cause;
                tval_o  = mem_tval;
            end
        end
    end
endmodule

// File: rtl/wb_fault_sel.sv
module wb_fault_sel
    import exc_arb_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit PRESENT = 1'b1
) (
    input  logic            valid_i,
    input  logic            done_i,
    input  logic            err_i,
    input  logic            store_i,
    input  logic [XLEN-1:0] addr_i,
    output logic            fault_o,
    output logic            busy_o,
    output cause_e          cause_o,
    output logic [XLEN-1:0] tval_o
);
    generate
        if (PRESENT) begin : g_wb
            assign fault_o = valid_i & done_i & err_i;
            assign busy_o  = valid_i & ~done_i;
            assign cause_o = store_i ? CAUSE_STORE : CAUSE_LOAD;
            assign tval_o  = addr_i;
        end else begin : g_nowb
            logic unused_wb_in;
            assign unused_wb_in = ^{valid_i, done_i, err_i, store_i, addr_i};
            assign fault_o = 1'b0;
            assign busy_o  = 1'b0;
            assign cause_o = CAUSE_NONE;
            assign tval_o  = '0;
        end
    endgenerate
endmodule

// File: rtl/nmi_tracker.sv
module nmi_tracker (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic ack_i,
    output logic pend_o
);
    typedef struct packed {
        logic pend;
    } nmi_st_t;

    nmi_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_i) st_d.pend = 1'b0;
        if (set_i) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R8: an error always leaves the request raised
    p_nmi_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> pend_o);
    // R8: request is sticky until acknowledged
    p_nmi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_arb_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit WB_STAGE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            idx_valid_i,
    input  logic [XLEN-1:0] idx_pc_i,
    input  logic            idx_fetch_err_i,
    input  logic            idx_fetch_hi_i,
    input  logic            idx_illegal_i,
    input  logic            idx_ecall_i,
    input  logic            idx_ebreak_i,
    input  logic            idx_mem_err_i,
    input  logic            idx_mem_store_i,
    input  logic [XLEN-1:0] idx_mem_addr_i,
    input  logic            wb_valid_i,
    input  logic            wb_done_i,
    input  logic            wb_err_i,
    input  logic            wb_store_i,
    input  logic [XLEN-1:0] wb_addr_i,
    input  logic            intg_err_i,
    input  logic            nmi_ack_i,
    output logic            trap_o,
    output logic [4:0]      cause_o,
    output logic [XLEN-1:0] tval_o,
    output logic            flush_o,
    output logic            nmi_req_o,
    output logic            id_adv_o,
    output logic            id_hold_o
);
    typedef struct packed {
        logic            trap;
        cause_e          cause;
        logic [XLEN-1:0] tval;
        logic            flush;
    } out_st_t;

    out_st_t st_d, st_q;

    logic            id_fault, wb_fault, wb_busy;
    cause_e          id_cause, wb_cause;
    logic [XLEN-1:0] id_tval, wb_tval;
    logic            take_wb, take_id;

    id_fault_sel #(.XLEN(XLEN), .INCL_MEM(!WB_STAGE)) i_id_sel (
        .valid_i     (idx_valid_i),
        .pc_i        (idx_pc_i),
        .fetch_err_i (idx_fetch_err_i),
        .fetch_hi_i  (idx_fetch_hi_i),
        .illegal_i   (idx_illegal_i),
        .ecall_i     (idx_ecall_i),
        .ebreak_i    (idx_ebreak_i),
        .mem_err_i   (idx_mem_err_i),
        .mem_store_i (idx_mem_store_i),
        .mem_addr_i  (idx_mem_addr_i),
        .fault_o     (id_fault),
        .cause_o     (id_cause),
        .tval_o      (id_tval)
    );

    wb_fault_sel #(.XLEN(XLEN), .PRESENT(WB_STAGE)) i_wb_sel (
        .valid_i (wb_valid_i),
        .done_i  (wb_done_i),
        .err_i   (wb_err_i),
        .store_i (wb_store_i),
        .addr_i  (wb_addr_i),
        .fault_o (wb_fault),
        .busy_o  (wb_busy),
        .cause_o (wb_cause),
        .tval_o  (wb_tval)
    );

    nmi_tracker i_nmi (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (intg_err_i),
        .ack_i  (nmi_ack_i),
        .pend_o (nmi_req_o)
    );

    // Writeback outranks decode; decode waits while writeback is busy.
    always_comb begin
        take_wb   = wb_fault;
        take_id   = id_fault & ~wb_fault & ~wb_busy;
        id_hold_o = id_fault & ~wb_fault & wb_busy;
        id_adv_o  = idx_valid_i & ~id_fault & ~wb_fault;

        st_d       = st_q;
        st_d.trap  = take_wb | take_id;
        st_d.cause = take_wb ? wb_cause : (take_id ? id_cause : CAUSE_NONE);
        st_d.tval  = take_wb ? wb_tval : (take_id ? id_tval : '0);
        st_d.flush = take_wb | take_id | nmi_ack_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign trap_o  = st_q.trap;
    assign cause_o = st_q.cause;
    assign tval_o  = st_q.tval;
    assign flush_o = st_q.flush;

    // R4: writeback memory fault wins a same-cycle collision
    p_wb_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_fault && id_fault) |=>
            (trap_o && (cause_o == CAUSE_LOAD || cause_o == CAUSE_STORE)));
    // R5: a held decode fault produces no trap
    p_hold_no_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_hold_o && !wb_fault) |=> !trap_o);
    // R9: every trap is accompanied by a flush
    p_trap_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> flush_o);
    // R10: a trapping decode instruction never advances
    p_no_adv_trap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        id_fault |-> !id_adv_o);
    // R3: second-half fetch fault reports PC plus 2
    p_tval_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_id && idx_fetch_err_i && idx_fetch_hi_i) |=>
            (tval_o == $past(idx_pc_i) + XLEN'(2)));
endmodule

// File: tb/test_exc_arbiter.sv
`timescale 1ns/1ps
module test_exc_arbiter;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic iv = 0, fe = 0, fh = 0, il = 0, ec = 0, eb = 0, me = 0, ms = 0;
    logic [XLEN-1:0] pc = '0, ma = '0, wa = '0;
    logic wv = 0, wd = 0, we = 0, ws = 0, ig = 0, ak = 0;

    logic t3, f3, n3, a3, h3, t2, f2, n2, a2, h2;
    logic [4:0] c3, c2;
    logic [XLEN-1:0] v3, v2;

    exc_arbiter #(.XLEN(XLEN), .WB_STAGE(1'b1)) i_exc_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .idx_valid_i(iv), .idx_pc_i(pc),
        .idx_fetch_err_i(fe), .idx_fetch_hi_i(fh), .idx_illegal_i(il),
        .idx_ecall_i(ec), .idx_ebreak_i(eb), .idx_mem_err_i(me),
        .idx_mem_store_i(ms), .idx_mem_addr_i(ma), .wb_valid_i(wv),
        .wb_done_i(wd), .wb_err_i(we), .wb_store_i(ws), .wb_addr_i(wa),
        .intg_err_i(ig), .nmi_ack_i(ak), .trap_o(t3), .cause_o(c3),
        .tval_o(v3), .flush_o(f3), .nmi_req_o(n3), .id_adv_o(a3), .id_hold_o(h3));

    exc_arbiter #(.XLEN(XLEN), .WB_STAGE(1'b0)) i_exc_arbiter_2s (
        .clk_i(clk), .rst_ni(rst_n), .idx_valid_i(iv), .idx_pc_i(pc),
        .idx_fetch_err_i(fe), .idx_fetch_hi_i(fh), .idx_illegal_i(il),
        .idx_ecall_i(ec), .idx_ebreak_i(eb), .idx_mem_err_i(me),
        .idx_mem_store_i(ms), .idx_mem_addr_i(ma), .wb_valid_i(wv),
        .wb_done_i(wd), .wb_err_i(we), .wb_store_i(ws), .wb_addr_i(wa),
        .intg_err_i(ig), .nmi_ack_i(ak), .trap_o(t2), .cause_o(c2),
        .tval_o(v2), .flush_o(f2), .nmi_req_o(n2), .id_adv_o(a2), .id_hold_o(h2));

    int checks = 0;
    int errors = 0;

    // expected registered state per variant (index 1 = writeback, 0 = two-stage)
    bit           ex_trap [2];
    int           ex_cause[2];
    logic [31:0]  ex_tval [2];
    bit           ex_flush[2];
    bit           ex_nmi = 0;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference of the decision for one variant
    task automatic model(input bit wbm, output bit take, output int cause,
                         output logic [31:0] tval, output bit hold, output bit adv);
        int idc;
        logic [31:0] idv;
        bit wbf;
        idc = 0; idv = 0;
        if (iv) begin
            if (fe)              begin idc = 1;  idv = fh ? pc + 2 : pc; end
            else if (il)         begin idc = 2;  idv = 0; end
            else if (ec)         begin idc = 11; idv = 0; end
            else if (eb)         begin idc = 3;  idv = pc; end
            else if (!wbm && me) begin idc = ms ? 7 : 5; idv = ma; end
        end
        wbf  = wbm && wv && wd && we;
        take = 0; cause = 0; tval = 0;
        hold = 0;
        adv  = iv && idc == 0 && !wbf;
        if (wbf) begin
            take = 1; cause = ws ? 7 : 5; tval = wa;
        end else if (idc != 0) begin
            if (wbm && wv && !wd) hold = 1;
            else begin take = 1; cause = idc; tval = idv; end
        end
    endtask

    // one clock: check combinational outputs, then registered ones
    task automatic cyc(string tag);
        bit tk, hd, ad; int cs; logic [31:0] tv;
        #1;
        for (int m = 0; m < 2; m++) begin
            model(m[0], tk, cs, tv, hd, ad);
            chk(tag, m ? "wb.id_adv" : "2s.id_adv", m ? a3 : a2, ad);
            chk(tag, m ? "wb.id_hold" : "2s.id_hold", m ? h3 : h2, hd);
            ex_trap[m] = tk; ex_cause[m] = cs; ex_tval[m] = tv;
            ex_flush[m] = tk || ak;
        end
        ex_nmi = ig ? 1'b1 : (ak ? 1'b0 : ex_nmi);
        @(posedge clk);
        #1;
        chk(tag, "wb.trap", t3, ex_trap[1]);   chk(tag, "2s.trap", t2, ex_trap[0]);
        chk(tag, "wb.cause", c3, ex_cause[1]); chk(tag, "2s.cause", c2, ex_cause[0]);
        chk(tag, "wb.tval", v3, ex_tval[1]);   chk(tag, "2s.tval", v2, ex_tval[0]);
        chk(tag, "wb.flush", f3, ex_flush[1]); chk(tag, "2s.flush", f2, ex_flush[0]);
        chk(tag, "wb.nmi", n3, ex_nmi);        chk(tag, "2s.nmi", n2, ex_nmi);
    endtask

    task automatic idle();
        iv = 0; fe = 0; fh = 0; il = 0; ec = 0; eb = 0; me = 0; ms = 0;
        wv = 0; wd = 0; we = 0; ws = 0; ig = 0; ak = 0;
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3;
        // R1: reset state
        chk("R1", "trap", t3 | t2, 0);   chk("R1", "flush", f3 | f2, 0);
        chk("R1", "nmi", n3 | n2, 0);    chk("R1", "cause", c3 | c2, 0);
        chk("R1", "tval", v3 | v2, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        cyc("R1");

        // R10: clean instruction advances
        iv = 1; pc = 32'h100; cyc("R10");
        // R2: priority among decode faults
        fe = 1; il = 1; ec = 1; eb = 1; cyc("R2");
        fe = 0; cyc("R2");
        il = 0; cyc("R2");
        ec = 0; cyc("R2");                 // ebreak, R3 tval = pc
        eb = 0; fe = 1; fh = 1; pc = 32'h2FE; cyc("R3");
        fh = 0; cyc("R3");
        idle();

        // R4: writeback fault collides with decode fault
        iv = 1; pc = 32'h400; il = 1;
        wv = 1; wd = 1; we = 1; ws = 0; wa = 32'hA0; cyc("R4");
        ws = 1; wa = 32'hB4; cyc("R4");
        idle();

        // R5: decode fault waits while writeback busy
        iv = 1; pc = 32'h500; ec = 1; wv = 1; cyc("R5");
        cyc("R5");
        wd = 1; cyc("R5");
        idle();

        // R6: writeback fault with no valid decode instruction
        wv = 1; wd = 1; we = 1; wa = 32'hC8; cyc("R6");
        idle();

        // R7: execute-stage memory fault (two-stage only), ranked last
        iv = 1; pc = 32'h600; me = 1; ma = 32'hD0; cyc("R7");
        ms = 1; cyc("R7");
        fe = 1; cyc("R7");
        fe = 0; wv = 1; wd = 1; we = 1; wa = 32'hE0; ms = 0; cyc("R7");
        idle();

        // R8: integrity error sets sticky request, no trap
        ig = 1; cyc("R8");
        ig = 0; cyc("R8"); cyc("R8");
        ak = 1; cyc("R9");                 // flush on handler entry
        ak = 0; cyc("R8");
        ig = 1; cyc("R8");
        ak = 1; cyc("R8");                 // set wins over ack
        ig = 0; cyc("R8");
        ak = 0;
        // R8/R9: integrity error together with a synchronous trap
        iv = 1; pc = 32'h700; il = 1; ig = 1; cyc("R9");
        idle(); cyc("R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule